// File: doc/BRIEF.md
# Storage Card Socket Status Register Block

This block gives software a small word-addressed register window onto a storage-card socket. Two socket signals come in: a write-protect level, which the block samples every clock and shows as it is, and a card-inserted indication. A card-inserted indication is latched into a sticky status bit. That bit drives the block's single interrupt line and stays set until software clears it by writing a one to it.

Besides the status word, the window has three fixed words: an identification word, a flash-programming word and an address-decode word. Flash programming and decode configuration are not implemented. Those words return constants, and writes to them are dropped. Reads are combinational: the read data is valid in the same cycle as the address. Writes take effect at the next rising clock edge.

Top module: `card_status_regs`

## Requirements
- R1: Word index 0 reads 0x41034003, word index 1 reads 0x00000000 and word index 3 reads 0x00000011.
- R2: Bit 0 of word index 2 reads the write-protect input level as sampled at the previous rising clock edge.
- R3: Bit 3 of word index 2 becomes 1 at the first rising edge at which the card-inserted input is high. It stays 1 after that input falls. Every other bit of word index 2 reads 0.
- R4: The interrupt output equals bit 3 of word index 2 in every cycle.
- R5: A write to word index 2 whose data has bit 3 set clears bit 3 at the next rising edge. A write whose data has bit 3 clear changes nothing, and no written bit other than bit 3 has any effect.
- R6: When a clear happens while the card-inserted input is still high, bit 3 reads 0 for exactly one cycle and then reads 1 again.
- R7: Writes to word indices 0, 1 and 3 change neither any read value nor the interrupt output.
- R8: After reset, word index 2 reads 0 and the interrupt output is low.
- R9: The read data is 0 when no read is selected, and 0 for any word index other than 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Access valid in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word index |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, combinational from the address |
| wpLevel | input | 1 | Card write-protect level |
| cardInsert | input | 1 | Card-inserted indication |
| cardIrq | output | 1 | Interrupt, high while the inserted bit is set |

## Verification
Read data depends combinationally on the address and on the registered state, so it is due in the same cycle as the read. A change on wpLevel or cardInsert, or a write, becomes visible one rising edge later. The interrupt line moves on that same edge. The bench drives every input at the falling edge and compares the outputs 1 ns later against a behavioural model. It advances that model only after the rising edge has consumed the driven inputs, so each comparison uses the state left by the edge before it.

// File: rtl/card_status_pkg.sv
package card_status_pkg;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_IDENT  = 3'd1,
    SEL_FLASH  = 3'd2,
    SEL_STATUS = 3'd3,
    SEL_DECODE = 3'd4
  } regSel_e;

  typedef struct packed {
    logic    clrCard;
    logic    rdEn;
    regSel_e sel;
  } ctlStrobe_t;

  localparam int unsigned WORD_IDENT  = 0;
  localparam int unsigned WORD_FLASH  = 1;
  localparam int unsigned WORD_STATUS = 2;
  localparam int unsigned WORD_DECODE = 3;

endpackage

// File: rtl/card_status_ctrl.sv
module card_status_ctrl
  import card_status_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CARD_BIT = 3
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output ctlStrobe_t        strb
);

  localparam logic [DATA_W-1:0] CARD_MASK = DATA_W'(1) << CARD_BIT;

  regSel_e           wordSel;
  logic [DATA_W-1:0] clearMask;

  always_comb begin
    unique case (busAddr)
      ADDR_W'(WORD_IDENT):  wordSel = SEL_IDENT;
      ADDR_W'(WORD_FLASH):  wordSel = SEL_FLASH;
      ADDR_W'(WORD_STATUS): wordSel = SEL_STATUS;
      ADDR_W'(WORD_DECODE): wordSel = SEL_DECODE;
      default:              wordSel = SEL_NONE;
    endcase
  end

  assign clearMask = busWrData & CARD_MASK;

  always_comb begin
    strb.sel     = wordSel;
    strb.rdEn    = busSel && !busWrite;
    strb.clrCard = busSel && busWrite && (wordSel == SEL_STATUS) && (|clearMask);
  end

endmodule

// File: rtl/card_status_dp.sv
module card_status_dp
  import card_status_pkg::*;
#(
  parameter int unsigned        DATA_W     = 32,
  parameter int unsigned        WP_BIT     = 0,
  parameter int unsigned        CARD_BIT   = 3,
  parameter logic [DATA_W-1:0]  IDENT_VAL  = DATA_W'(32'h4103_4003),
  parameter logic [DATA_W-1:0]  FLASH_VAL  = '0,
  parameter logic [DATA_W-1:0]  DECODE_VAL = DATA_W'(32'h0000_0011)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strb,
  input  logic              wpLevel,
  input  logic              cardInsert,
  output logic [DATA_W-1:0] rdData,
  output logic              cardIrq
);

  logic              wpBit;
  logic              cardBit;
  logic [DATA_W-1:0] statusWord;

  // Write-protect is sampled every cycle; it is never latched.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wpBit <= 1'b0;
    else        wpBit <= wpLevel;
  end

  // The inserted bit is sticky. A clear wins in its own cycle, so a
  // still-asserted input sets the bit again one edge later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cardBit <= 1'b0;
    else if (strb.clrCard) cardBit <= 1'b0;
    else if (cardInsert)   cardBit <= 1'b1;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[WP_BIT]   = wpBit;
    statusWord[CARD_BIT] = cardBit;
  end

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      unique case (strb.sel)
        SEL_IDENT:  rdData = IDENT_VAL;
        SEL_FLASH:  rdData = FLASH_VAL;
        SEL_STATUS: rdData = statusWord;
        SEL_DECODE: rdData = DECODE_VAL;
        default:    rdData = '0;
      endcase
    end
  end

  assign cardIrq = cardBit;

  assert_wp_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wpBit == $past(wpLevel)));

  assert_card_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cardInsert && !strb.clrCard) |=> cardBit);

  assert_card_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cardBit && !strb.clrCard) |=> cardBit);

  assert_card_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrCard |=> !cardBit);

endmodule

// File: rtl/card_status_regs.sv
module card_status_regs
  import card_status_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WP_BIT   = 0,
  parameter int unsigned CARD_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              wpLevel,
  input  logic              cardInsert,
  output logic              cardIrq
);

  ctlStrobe_t strb;

  card_status_ctrl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CARD_BIT(CARD_BIT)
  ) ctrl_i (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strb     (strb)
  );

  card_status_dp #(
    .DATA_W  (DATA_W),
    .WP_BIT  (WP_BIT),
    .CARD_BIT(CARD_BIT)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .wpLevel   (wpLevel),
    .cardInsert(cardInsert),
    .rdData    (busRdData),
    .cardIrq   (cardIrq)
  );

  // The interrupt only rises after an inserted indication was seen.
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cardIrq) |-> $past(cardInsert));

  // A write outside the status word never lowers the interrupt.
  assert_other_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && busWrite && busAddr != ADDR_W'(WORD_STATUS) && cardIrq) |=> cardIrq);

endmodule

// File: tb/card_status_regs_tb_top.sv
module card_status_regs_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              wpLevel = 1'b0;
  logic              cardInsert = 1'b0;
  logic              cardIrq;

  int    nRun = 0;
  int    nFail = 0;
  bit    refWp = 0;
  bit    refCard = 0;
  string curReq = "R8";

  always #(CLK_PERIOD / 2) clk = ~clk;

  card_status_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .wpLevel(wpLevel), .cardInsert(cardInsert), .cardIrq(cardIrq));

  function automatic logic [31:0] expRead();
    if (!(busSel && !busWrite)) return 32'h0;
    case (busAddr)
      8'd0: return 32'h4103_4003;
      8'd1: return 32'h0;
      8'd2: return {28'h0, refCard, 2'b00, refWp};
      8'd3: return 32'h0000_0011;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare 1 ns later, then let the
  // reference take the rising edge.
  task automatic step(input bit sel, input bit wr, input int addr,
                      input logic [31:0] data, input bit wp, input bit ins);
    logic [31:0] e;
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = ADDR_W'(addr); busWrData = data;
    wpLevel = wp; cardInsert = ins;
    #1;
    e = expRead();
    check(busRdData === e, curReq, busRdData, e);
    check(cardIrq === refCard, "R4", {31'h0, cardIrq}, {31'h0, refCard});
    @(posedge clk);
    if (sel && wr && addr == 2 && data[3]) refCard = 0;
    else if (ins) refCard = 1;
    refWp = wp;
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    curReq = "R8";
    step(1, 0, 2, 0, 0, 0);
    curReq = "R1";
    for (int a = 0; a < 4; a++) step(1, 0, a, 0, 0, 0);
    curReq = "R9";
    step(1, 0, 5, 0, 0, 0);
    step(1, 0, 255, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    curReq = "R2";
    step(1, 0, 2, 0, 1, 0);
    step(1, 0, 2, 0, 1, 0);
    step(1, 0, 2, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0);
    curReq = "R3";
    step(1, 0, 2, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 2, 0, i[0], 0);
    curReq = "R5";
    step(1, 1, 2, 32'hFFFF_FFF7, 0, 0);
    step(1, 0, 2, 0, 0, 0);
    step(1, 1, 2, 32'h0000_0008, 1, 0);
    step(1, 0, 2, 0, 1, 0);
    step(1, 0, 2, 0, 0, 0);
    curReq = "R7";
    step(1, 0, 2, 0, 0, 1);
    step(1, 1, 1, 32'hFFFF_FFFF, 0, 0);
    step(1, 1, 3, 32'hFFFF_FFFF, 0, 0);
    step(1, 1, 0, 32'hFFFF_FFFF, 0, 0);
    for (int a = 0; a < 4; a++) step(1, 0, a, 0, 0, 0);
    curReq = "R6";
    step(1, 0, 2, 0, 0, 1);
    step(1, 1, 2, 32'h0000_0008, 0, 1);
    step(1, 0, 2, 0, 0, 1);
    step(1, 0, 2, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0);
    curReq = "R5";
    step(1, 1, 2, 32'h0000_0008, 0, 0);
    step(1, 0, 2, 0, 0, 0);
    curReq = "R3";
    for (int i = 0; i < 20; i++) step(1, 0, i % 6, 0, i[1], i[2] & i[0]);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule